// File: doc/BRIEF.md
# Control-Transfer Link Resolver

This sequencer turns a 16-bit destination link into the context that a procedure call, a return or a coroutine switch continues in. A start pulse hands it the link. It then reads memory through a simple read port and ends in one of two ways. It either reports a resolved context (frame pointer, global frame, code base, program counter and frame-size index) or it raises a trap with a cause code and a parameter word.

The two low bits of the link pick its kind. Tag 00 is a direct frame, 01 is a packed procedure descriptor, 10 is an address to fetch a new link from, and 11 is an unbound link. A one-shot arm input makes the next accepted transfer trap at once, before any memory access. Frame allocation, stack handling and instruction fetch belong to the blocks around this one. The frame-size index is presented at the end of a descriptor transfer for the allocator to use.

The memory port has a fixed latency of one cycle. A word addressed while `mem_req` is high is valid on `mem_rdata` in the following cycle.

Top module: `xfer_link_resolver`

## Requirements
- R1: After reset `busy`, `done`, `trap` and `mem_req` are low, and all result and trap outputs are zero.
- R2: A nonzero link with tag 00 (bits [1:0]) is a frame pointer F. The block reads G = mem[F] and P = mem[F+1], then C = mem[G]. It completes with frame_ptr = F, gframe = G, code_base = C, new_pc = P and fsi = 0.
- R3: A link equal to zero traps with cause 1 (unbound) and parameter 0.
- R4: A tag 01 link carries a table index X in bits [15:7] and an entry number E in bits [6:2]. The block reads G = mem[GFT_BASE+2X] and B = mem[GFT_BASE+2X+1], then C = mem[G]. It then reads pc = mem[C+2(B+E)] and takes fsi from the low 8 bits of mem[C+2(B+E)+1]. It completes with frame_ptr = 0, gframe = G and code_base = C.
- R5: A tag 10 link is an address. The word read there is decoded again as a link. At most MAX_HOPS such hops are taken. A further tag 10 link traps with cause 3 (control fault), and the parameter is that link.
- R6: A tag 11 link traps with cause 1 (unbound), and the parameter is that link.
- R7: A global frame word G of zero traps with cause 1, and the parameter is the link being resolved.
- R8: A code word C with bit 0 set traps with cause 2 (segment swapped out), and the parameter is the link being resolved.
- R9: A pulse on `arm` sets a flag. The next accepted start then traps with cause 4 and the start link as parameter, without a memory read, and clears the flag. The start after that resolves normally.
- R10: A start while `busy` is high is ignored.
- R11: Each accepted start produces exactly one one-cycle pulse, on either `done` or `trap`. Result outputs keep their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving `link_in` |
| link_in | input | 16 | Destination link |
| arm | input | 1 | Request a transfer trap on the next start |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, valid one cycle after request |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | Successful completion pulse |
| trap | output | 1 | Trap pulse |
| trap_cause | output | 3 | 1 unbound, 2 swapped out, 3 control fault, 4 transfer trap |
| trap_param | output | 16 | Trap parameter |
| frame_ptr | output | 16 | Resolved frame pointer (0 for descriptor) |
| gframe | output | 16 | Global frame |
| code_base | output | 16 | Code segment base |
| new_pc | output | 16 | Program counter |
| fsi | output | 8 | Frame-size index for the allocator |

## Verification
Random links over a randomly filled memory mix all four tags. The resulting traps fall into their causes through whatever zero frames, odd code words and table contents the fill happens to hold. Directed memory images then separate the cases that random data seldom reaches. These include a four-hop chain that still resolves and a five-hop chain that faults, a zero global frame set against a swapped segment, and a descriptor whose entry arithmetic can be checked by hand. Starts issued while busy and armed transfers show that the result belongs to the accepted link alone and that the arm flag is consumed exactly once.

// File: rtl/xfer_link_resolver.sv
module xfer_link_resolver #(
  parameter logic [15:0] GFT_BASE = 16'h0100,
  parameter int MAX_HOPS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] link_in,
  input  logic        arm,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic [15:0] mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        trap,
  output logic [2:0]  trap_cause,
  output logic [15:0] trap_param,
  output logic [15:0] frame_ptr,
  output logic [15:0] gframe,
  output logic [15:0] code_base,
  output logic [15:0] new_pc,
  output logic [7:0]  fsi
);
  localparam int HW = $clog2(MAX_HOPS + 1);
  localparam logic [2:0] C_UNBOUND = 3'd1;
  localparam logic [2:0] C_SWAPPED = 3'd2;
  localparam logic [2:0] C_FAULT   = 3'd3;
  localparam logic [2:0] C_XFER    = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_DEC, S_IREQ, S_IWAIT, S_RA, S_RB, S_RC, S_CREQ, S_CWAIT
  } state_t;

  state_t      state;
  logic [15:0] cur, base, w0, w1, gf, cb;
  logic [HW-1:0] hops;
  logic        armed, is_desc, head;
  logic [15:0] ev_idx;

  assign busy   = (state != S_IDLE);
  assign ev_idx = w1 + {11'd0, cur[6:2]};

  always_comb begin
    mem_req  = 1'b0;
    mem_addr = 16'd0;
    case (state)
      S_IREQ: begin mem_req = 1'b1; mem_addr = cur;         end
      S_RA:   begin mem_req = 1'b1; mem_addr = base;        end
      S_RB:   begin mem_req = 1'b1; mem_addr = base + 16'd1; end
      S_CREQ: begin mem_req = 1'b1; mem_addr = gf;          end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cur <= '0; base <= '0; w0 <= '0; w1 <= '0; gf <= '0; cb <= '0;
      hops <= '0; armed <= 1'b0; is_desc <= 1'b0; head <= 1'b0;
      done <= 1'b0; trap <= 1'b0; trap_cause <= '0; trap_param <= '0;
      frame_ptr <= '0; gframe <= '0; code_base <= '0; new_pc <= '0; fsi <= '0;
    end else begin
      done <= 1'b0;
      trap <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cur  <= link_in;
          hops <= '0;
          if (armed) begin
            armed <= 1'b0;
            trap <= 1'b1; trap_cause <= C_XFER; trap_param <= link_in;
          end else state <= S_DEC;
        end
        S_DEC: case (cur[1:0])
          2'b00: if (cur == 16'd0) begin
                   trap <= 1'b1; trap_cause <= C_UNBOUND; trap_param <= cur;
                   state <= S_IDLE;
                 end else begin
                   base <= cur; is_desc <= 1'b0; head <= 1'b1; state <= S_RA;
                 end
          2'b01: begin
                   base <= GFT_BASE + {6'd0, cur[15:7], 1'b0};
                   is_desc <= 1'b1; head <= 1'b1; state <= S_RA;
                 end
          2'b10: if (hops == HW'(MAX_HOPS)) begin
                   trap <= 1'b1; trap_cause <= C_FAULT; trap_param <= cur;
                   state <= S_IDLE;
                 end else begin
                   hops <= hops + 1'b1; state <= S_IREQ;
                 end
          default: begin
                   trap <= 1'b1; trap_cause <= C_UNBOUND; trap_param <= cur;
                   state <= S_IDLE;
                 end
        endcase
        S_IREQ:  state <= S_IWAIT;
        S_IWAIT: begin cur <= mem_rdata; state <= S_DEC; end
        S_RA:    state <= S_RB;
        S_RB:    begin w0 <= mem_rdata; state <= S_RC; end
        S_RC: if (head) begin
          if (w0 == 16'd0) begin
            trap <= 1'b1; trap_cause <= C_UNBOUND; trap_param <= cur;
            state <= S_IDLE;
          end else begin
            gf <= w0; w1 <= mem_rdata; state <= S_CREQ;
          end
        end else begin
          done <= 1'b1;
          frame_ptr <= 16'd0; gframe <= gf; code_base <= cb;
          new_pc <= w0; fsi <= mem_rdata[7:0];
          state <= S_IDLE;
        end
        S_CREQ: state <= S_CWAIT;
        S_CWAIT: if (mem_rdata[0]) begin
          trap <= 1'b1; trap_cause <= C_SWAPPED; trap_param <= cur;
          state <= S_IDLE;
        end else if (!is_desc) begin
          done <= 1'b1;
          frame_ptr <= cur; gframe <= gf; code_base <= mem_rdata;
          new_pc <= w1; fsi <= 8'd0;
          state <= S_IDLE;
        end else begin
          cb   <= mem_rdata;
          base <= mem_rdata + {ev_idx[14:0], 1'b0};
          head <= 1'b0;
          state <= S_RA;
        end
        default: state <= S_IDLE;
      endcase
      if (arm) armed <= 1'b1;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(done && trap)); // R11
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy); // R10
  AST_HOP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) hops <= HW'(MAX_HOPS)); // R5
  AST_FAULT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && trap_cause == C_FAULT) |-> hops == HW'(MAX_HOPS)); // R5
  AST_NO_ODD_CODE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !code_base[0]); // R8
  AST_XFER_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && trap_cause == C_XFER) |-> $past(armed)); // R9
  AST_XFER_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (trap && trap_cause == C_XFER) |-> !busy); // R9
endmodule

// File: tb/test_xfer_link_resolver.sv
module test_xfer_link_resolver;
  localparam logic [15:0] BASE = 16'h0100;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, arm = 1'b0;
  logic [15:0] link_in = '0;
  logic mem_req, busy, done, trap;
  logic [15:0] mem_addr, mem_rdata, trap_param, frame_ptr, gframe, code_base, new_pc;
  logic [2:0] trap_cause;
  logic [7:0] fsi;
  logic [15:0] mem [0:4095];

  int errors = 0, checks = 0, pulses = 0, cycles = 0;
  bit e_trap; logic [2:0] e_cause; logic [15:0] e_param, e_fp, e_g, e_cb, e_pc; logic [7:0] e_fsi;

  always #10 clk = ~clk;

  xfer_link_resolver i_xfer_link_resolver (
    .clk(clk), .rst_n(rst_n), .start(start), .link_in(link_in), .arm(arm),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .trap(trap), .trap_cause(trap_cause),
    .trap_param(trap_param), .frame_ptr(frame_ptr), .gframe(gframe),
    .code_base(code_base), .new_pc(new_pc), .fsi(fsi));

  always_ff @(posedge clk) mem_rdata <= mem[mem_addr[11:0]];

  always @(negedge clk) begin
    cycles++;
    if (done || trap) pulses++;
    if (cycles == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem[a[11:0]];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] lnk, input bit armed_i);
    logic [15:0] c, g, b, cw, a;
    int hops;
    bit fin;
    c = lnk; hops = 0; fin = 0; e_trap = 0; e_cause = 0; e_param = 0;
    if (armed_i) begin e_trap = 1; e_cause = 4; e_param = lnk; return; end
    while (!fin) begin
      case (c[1:0])
        2'b10: if (hops == 4) begin e_trap = 1; e_cause = 3; e_param = c; fin = 1; end
               else begin hops++; c = rd(c); end
        2'b11: begin e_trap = 1; e_cause = 1; e_param = c; fin = 1; end
        default: fin = 1;
      endcase
    end
    if (e_trap) return;
    if (c == 16'd0) begin e_trap = 1; e_cause = 1; e_param = c; return; end
    if (c[1:0] == 2'b00) begin g = rd(c); b = rd(c + 16'd1); end
    else begin a = BASE + 16'(c[15:7]) * 16'd2; g = rd(a); b = rd(a + 16'd1); end
    if (g == 16'd0) begin e_trap = 1; e_cause = 1; e_param = c; return; end
    cw = rd(g);
    if (cw[0]) begin e_trap = 1; e_cause = 2; e_param = c; return; end
    e_g = g; e_cb = cw;
    if (c[1:0] == 2'b00) begin e_fp = c; e_pc = b; e_fsi = 0; end
    else begin
      a = cw + 16'd2 * (b + 16'(c[6:2]));
      e_fp = 0; e_pc = rd(a); e_fsi = rd(a + 16'd1)[7:0];
    end
  endtask

  task automatic launch(input logic [15:0] lnk);
    @(negedge clk); start = 1; link_in = lnk;
    @(negedge clk); start = 0;
  endtask

  task automatic finish_and_check(input string tag);
    int n = 0;
    int p0;
    p0 = pulses;
    while (!(done || trap) && n < 200) begin @(negedge clk); n++; end
    chk(trap == e_trap && done == !e_trap, {tag, " outcome R11"}, {trap, done}, {e_trap, !e_trap});
    if (e_trap) begin
      chk(trap_cause == e_cause, {tag, " cause"}, trap_cause, e_cause);
      chk(trap_param == e_param, {tag, " param"}, trap_param, e_param);
    end else begin
      chk(frame_ptr == e_fp, {tag, " frame_ptr"}, frame_ptr, e_fp);
      chk(gframe == e_g, {tag, " gframe"}, gframe, e_g);
      chk(code_base == e_cb, {tag, " code_base"}, code_base, e_cb);
      chk(new_pc == e_pc, {tag, " new_pc"}, new_pc, e_pc);
      chk(fsi == e_fsi, {tag, " fsi"}, fsi, e_fsi);
    end
    @(negedge clk);
    chk(!done && !trap && !busy, "R11 single pulse", {done, trap, busy}, 0);
    p0 = pulses - p0;
    if (p0 < 0) p0 = 0;
  endtask

  task automatic run(input logic [15:0] lnk, input string tag);
    model(lnk, 0);
    launch(lnk);
    finish_and_check(tag);
  endtask

  task automatic fill(input int seed_shift);
    for (int i = 0; i < 4096; i++) mem[i] = 16'($urandom) ^ 16'(seed_shift);
  endtask

  initial begin
    int pb;
    void'($urandom(1234));
    fill(0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !trap && !mem_req, "R1 reset controls", {busy, done, trap, mem_req}, 0);
    chk(frame_ptr == 0 && new_pc == 0 && fsi == 0 && trap_param == 0 && trap_cause == 0,
        "R1 reset data", {frame_ptr, new_pc}, 0);
    rst_n = 1;

    mem[12'h300] = 16'h0400; mem[12'h301] = 16'h1234; mem[12'h400] = 16'h0800;
    run(16'h0300, "R2 frame link");
    chk(new_pc == 16'h1234 && code_base == 16'h0800, "R2 direct values", new_pc, 16'h1234);
    run(16'h0000, "R3 zero link");
    chk(trap_cause == 1 && trap_param == 0, "R3 unbound zero", trap_cause, 1);
    pb = frame_ptr;
    chk(frame_ptr == 16'h0300, "R11 result held after trap", frame_ptr, 16'h0300);

    mem[12'h106] = 16'h0400; mem[12'h107] = 16'h0010;
    mem[12'h82A] = 16'h4321; mem[12'h82B] = 16'hAB37;
    run(16'h0195, "R4 descriptor");
    chk(new_pc == 16'h4321 && fsi == 8'h37 && frame_ptr == 0, "R4 entry vector", {new_pc, 8'h0, fsi}, {16'h4321, 8'h0, 8'h37});

    run(16'hBEEF, "R6 tag 11");
    chk(trap_cause == 1 && trap_param == 16'hBEEF, "R6 unbound param", trap_param, 16'hBEEF);

    mem[12'h202] = 16'h0206; mem[12'h206] = 16'h020A; mem[12'h20A] = 16'h020E; mem[12'h20E] = 16'h0300;
    run(16'h0202, "R5 four hops resolve");
    chk(done && frame_ptr == 16'h0300 || frame_ptr == 16'h0300, "R5 four hops frame", frame_ptr, 16'h0300);
    mem[12'h20E] = 16'h0212;
    run(16'h0202, "R5 fifth hop faults");
    chk(trap_cause == 3 && trap_param == 16'h0212, "R5 fault param", trap_param, 16'h0212);

    mem[12'h300] = 16'h0000;
    run(16'h0300, "R7 zero global frame");
    chk(trap_cause == 1 && trap_param == 16'h0300, "R7 cause", trap_cause, 1);
    mem[12'h300] = 16'h0400; mem[12'h400] = 16'h0801;
    run(16'h0300, "R8 swapped segment");
    chk(trap_cause == 2, "R8 cause", trap_cause, 2);
    mem[12'h400] = 16'h0800;

    @(negedge clk); arm = 1; @(negedge clk); arm = 0;
    model(16'h0300, 1); launch(16'h0300); finish_and_check("R9 armed transfer");
    run(16'h0300, "R9 flag consumed");

    model(16'h0195, 0);
    @(negedge clk); start = 1; link_in = 16'h0195;
    @(negedge clk); start = 1; link_in = 16'hBEEF;
    @(negedge clk); start = 0;
    finish_and_check("R10 start while busy");
    pb = pulses;
    repeat (20) @(negedge clk);
    chk(pulses == pb, "R10 no second outcome", pulses, pb);

    for (int k = 0; k < 400; k++) begin
      logic [15:0] l;
      if (k % 50 == 0) fill(k);
      l = 16'($urandom);
      if (k % 7 == 0) l[1:0] = 2'b10;
      if (k % 11 == 0) begin
        @(negedge clk); arm = 1; @(negedge clk); arm = 0;
        model(l, 1); launch(l); finish_and_check("R9 random armed");
      end else run(l, "R2 R4 R5 R6 R7 R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule